// File: doc/BRIEF.md
# Ternary Block Nine-Code Serial Encoder

This block compresses scan test data that contains don't-care positions. Each K-bit block arrives in parallel as two vectors: the bit values and a care mask, where a care bit of 1 marks a specified position and 0 marks a don't-care. The block is cut into a left half (the upper K/2 bits) and a right half (the lower K/2 bits). Each half is rated as all-zero, all-one or mixed. The pair of ratings selects one of nine prefix-free codewords. Some codewords are followed by the raw bits of one half or of the whole block.

The resulting frame leaves one bit per cycle on a valid/ready serial port. A consumer on the chip can rebuild the block with a small state machine and a K/2-bit shifter. Don't-care positions that must travel as raw payload are sent as 0. A parallel flag marks them, so a later stage may refill them.

Top module: `tern_block_encoder`

## Requirements
- R1: A half whose specified bits are all 0 is rated zero, and a half whose specified bits are all 1 is rated one. A half with at least one specified 0 and at least one specified 1 is rated mixed. Care bit 1 means specified.
- R2: A half with no specified bit takes the rating of the other half when that half is zero or one. When both halves have no specified bit, the block is coded as zero/zero, which is the single bit "0".
- R3: A half with no specified bit, paired with a mixed half, is rated zero.
- R4: The codewords, written left rating then right rating, are: zero/zero "0"; one/one "10"; zero/one "11000"; one/zero "11001"; one/mixed "11010"; mixed/one "11011"; zero/mixed "11100"; mixed/zero "11101"; mixed/mixed "1111". The leftmost character is sent first.
- R5: After a code with exactly one mixed half, the K/2 bits of that half are sent. After the mixed/mixed code, all K bits are sent. Payload goes from the most significant block bit down to the least.
- R6: A frame is 1, 2, 5, 5+K/2 or 4+K bits long. out_valid falls after the last bit of the frame is taken.
- R7: A payload bit at a don't-care position is sent as 0 with out_dc=1. Every codeword bit and every specified payload bit has out_dc=0.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_bit and out_dc hold their values into the next cycle.
- R9: A block is taken on a clock edge where in_valid and in_ready are both 1. in_ready is 0 from the next cycle on, and the first frame bit is valid in that cycle. in_ready returns to 1 in the cycle after the edge that takes the last bit, and in_ready and out_valid are never 1 together.
- R10: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | Encoder can take a block |
| in_value | input | K | Bit values of the block; bit K-1 is leftmost |
| in_care | input | K | 1 where the bit is specified, 0 for don't-care |
| out_valid | output | 1 | out_bit carries a frame bit |
| out_ready | input | 1 | Consumer takes out_bit this cycle |
| out_bit | output | 1 | Current serial frame bit |
| out_dc | output | 1 | Current bit is a payload don't-care sent as 0 |

## Verification
The bench feeds blocks that single out each rating rule:
- Halves with no specified bit, on their own and beside zero, one and mixed halves. An encoder that resolved these wrongly would emit a longer code or a needless payload.
- Sparse care masks whose specified bits agree. A classifier that ignored the mask would call these halves mixed.
- Payloads holding don't-cares. These expose a wrong bit order, a missing flag or a leaked value bit.

Random stalls on out_ready expose a frame that moves on without a handshake. Checking the idle state right after each last bit exposes frames that are too short or too long, and a start of the next block that comes too early or too late.

// File: rtl/tbe_pkg.sv
package tbe_pkg;

  // Rating of one half-block after the care mask is applied.
  typedef enum logic [1:0] {
    HC_ZERO = 2'd0,
    HC_ONE  = 2'd1,
    HC_MIX  = 2'd2,
    HC_NONE = 2'd3
  } halfCls_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic shift;
  } strobe_t;

endpackage

// File: rtl/tbe_classify.sv
module tbe_classify
  import tbe_pkg::*;
#(
  parameter int K = 8
) (
  input  logic [K-1:0]   blkValue,
  input  logic [K-1:0]   blkCare,
  output logic [K+4:0]   frameBits,
  output logic [K+4:0]   frameDc,
  output logic [$clog2(K+6)-1:0] frameLen
);
  localparam int HALF = K / 2;
  localparam int FW   = K + 5;
  localparam int LW   = $clog2(FW + 1);
  localparam logic [LW-1:0] FWL   = LW'(FW);
  localparam logic [LW-1:0] HALFL = LW'(HALF);
  localparam logic [LW-1:0] KL    = LW'(K);

  function automatic halfCls_t rateHalf(input logic [HALF-1:0] v, input logic [HALF-1:0] c);
    logic hasOne, hasZero;
    hasOne  = |(v & c);
    hasZero = |(~v & c);
    if (hasOne && hasZero) return HC_MIX;
    if (hasOne)            return HC_ONE;
    if (hasZero)           return HC_ZERO;
    return HC_NONE;
  endfunction

  // Index 1 is the left (upper) half, index 0 the right half.
  halfCls_t        rawCls [2];
  logic [HALF-1:0] cleanVal [2];
  logic [HALF-1:0] dcMask [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign rawCls[h]   = rateHalf(blkValue[h*HALF +: HALF], blkCare[h*HALF +: HALF]);
    assign cleanVal[h] = blkValue[h*HALF +: HALF] & blkCare[h*HALF +: HALF];
    assign dcMask[h]   = ~blkCare[h*HALF +: HALF];
  end

  halfCls_t leftRes, rightRes;
  always_comb begin
    leftRes  = rawCls[1];
    rightRes = rawCls[0];
    if (rawCls[1] == HC_NONE && rawCls[0] == HC_NONE) begin
      leftRes  = HC_ZERO;
      rightRes = HC_ZERO;
    end else if (rawCls[1] == HC_NONE) begin
      leftRes = (rawCls[0] == HC_MIX) ? HC_ZERO : rawCls[0];
    end else if (rawCls[0] == HC_NONE) begin
      rightRes = (rawCls[1] == HC_MIX) ? HC_ZERO : rawCls[1];
    end
  end

  logic [4:0]    codeWord;
  logic [LW-1:0] codeLen;
  logic [LW-1:0] payLen;
  logic [K-1:0]  payVal;
  logic [K-1:0]  payDc;
  logic [LW-1:0] shiftAmt;

  always_comb begin
    codeWord = 5'b00000;
    codeLen  = LW'(1);
    payLen   = '0;
    payVal   = '0;
    payDc    = '0;
    unique case ({leftRes, rightRes})
      {HC_ZERO, HC_ZERO}: begin codeWord = 5'b00000; codeLen = LW'(1); end
      {HC_ONE,  HC_ONE }: begin codeWord = 5'b10000; codeLen = LW'(2); end
      {HC_ZERO, HC_ONE }: begin codeWord = 5'b11000; codeLen = LW'(5); end
      {HC_ONE,  HC_ZERO}: begin codeWord = 5'b11001; codeLen = LW'(5); end
      {HC_ONE,  HC_MIX }: begin
        codeWord = 5'b11010; codeLen = LW'(5); payLen = HALFL;
        payVal = {{HALF{1'b0}}, cleanVal[0]}; payDc = {{HALF{1'b0}}, dcMask[0]};
      end
      {HC_MIX,  HC_ONE }: begin
        codeWord = 5'b11011; codeLen = LW'(5); payLen = HALFL;
        payVal = {{HALF{1'b0}}, cleanVal[1]}; payDc = {{HALF{1'b0}}, dcMask[1]};
      end
      {HC_ZERO, HC_MIX }: begin
        codeWord = 5'b11100; codeLen = LW'(5); payLen = HALFL;
        payVal = {{HALF{1'b0}}, cleanVal[0]}; payDc = {{HALF{1'b0}}, dcMask[0]};
      end
      {HC_MIX,  HC_ZERO}: begin
        codeWord = 5'b11101; codeLen = LW'(5); payLen = HALFL;
        payVal = {{HALF{1'b0}}, cleanVal[1]}; payDc = {{HALF{1'b0}}, dcMask[1]};
      end
      {HC_MIX,  HC_MIX }: begin
        codeWord = 5'b11110; codeLen = LW'(4); payLen = KL;
        payVal = {cleanVal[1], cleanVal[0]}; payDc = {dcMask[1], dcMask[0]};
      end
      default: begin codeWord = 5'b00000; codeLen = LW'(1); end
    endcase
  end

  // Payload sits right after the code inside a left-aligned frame.
  assign shiftAmt  = FWL - codeLen - payLen;
  assign frameBits = {codeWord, {K{1'b0}}} | ({5'b00000, payVal} << shiftAmt);
  assign frameDc   = {5'b00000, payDc} << shiftAmt;
  assign frameLen  = codeLen + payLen;

endmodule

// File: rtl/tbe_ctrl.sv
module tbe_ctrl
  import tbe_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic          outReady,
  input  logic [LW-1:0] frameLen,
  output logic          inReady,
  output logic          outValid,
  output strobe_t       strobe
);
  typedef enum logic {ST_IDLE, ST_SEND} ctlState_t;

  ctlState_t     state;
  logic [LW-1:0] remain;

  assign inReady      = (state == ST_IDLE);
  assign outValid     = (state == ST_SEND);
  assign strobe.load  = inReady && inValid;
  assign strobe.shift = outValid && outReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else if (strobe.load) begin
      state  <= ST_SEND;
      remain <= frameLen;
    end else if (strobe.shift) begin
      remain <= remain - LW'(1);
      if (remain == LW'(1)) state <= ST_IDLE;
    end
  end

endmodule

// File: rtl/tbe_datapath.sv
module tbe_datapath
  import tbe_pkg::*;
#(
  parameter int FW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       strobe,
  input  logic [FW-1:0] frameBits,
  input  logic [FW-1:0] frameDc,
  output logic          outBit,
  output logic          outDc
);
  logic [FW-1:0] bitReg;
  logic [FW-1:0] dcReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitReg <= '0;
      dcReg  <= '0;
    end else if (strobe.load) begin
      bitReg <= frameBits;
      dcReg  <= frameDc;
    end else if (strobe.shift) begin
      bitReg <= {bitReg[FW-2:0], 1'b0};
      dcReg  <= {dcReg[FW-2:0], 1'b0};
    end
  end

  assign outBit = bitReg[FW-1];
  assign outDc  = dcReg[FW-1];

endmodule

// File: rtl/tern_block_encoder.sv
module tern_block_encoder
  import tbe_pkg::*;
#(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_value,
  input  logic [K-1:0] in_care,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_bit,
  output logic         out_dc
);
  localparam int FW = K + 5;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] frameBits;
  logic [FW-1:0] frameDc;
  logic [LW-1:0] frameLen;
  strobe_t       strobe;

  tbe_classify #(.K(K)) u_classify (
    .blkValue (in_value),
    .blkCare  (in_care),
    .frameBits(frameBits),
    .frameDc  (frameDc),
    .frameLen (frameLen)
  );

  tbe_ctrl #(.LW(LW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (in_valid),
    .outReady(out_ready),
    .frameLen(frameLen),
    .inReady (in_ready),
    .outValid(out_valid),
    .strobe  (strobe)
  );

  tbe_datapath #(.FW(FW)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .frameBits(frameBits),
    .frameDc  (frameDc),
    .outBit   (out_bit),
    .outDc    (out_dc)
  );

endmodule

// File: rtl/tbe_checker.sv
module tbe_checker #(
  parameter int K = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_dc
);
  localparam int HALF = K / 2;
  localparam int LW   = $clog2(K + 6);

  logic [LW-1:0] sentCnt;
  logic          lenOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sentCnt <= '0;
    else if (in_valid && in_ready)    sentCnt <= '0;
    else if (out_valid && out_ready)  sentCnt <= sentCnt + LW'(1);
  end

  assign lenOk = (sentCnt == LW'(1)) || (sentCnt == LW'(2)) || (sentCnt == LW'(5)) ||
                 (sentCnt == LW'(5 + HALF)) || (sentCnt == LW'(4 + K));

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_dc)));

  // R7
  dc_sent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dc) |-> !out_bit);

  // R9
  accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !in_ready));

  // R6
  frame_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> lenOk);

  // R9
  ready_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> in_ready);

endmodule

bind tern_block_encoder tbe_checker #(.K(K)) u_tbe_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_bit  (out_bit),
  .out_dc   (out_dc)
);

// File: tb/tb_tern_block_encoder.sv
module tb_tern_block_encoder;
  localparam int K    = 8;
  localparam int HALF = K / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [K-1:0] in_value = '0;
  logic [K-1:0] in_care = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_bit;
  logic         out_dc;

  tern_block_encoder #(.K(K)) dut (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic       b;
    logic       d;
    logic       last;
    logic [7:0] req;
  } expItem_t;

  expItem_t expQ[$];
  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;
  bit  stallMode = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input bit ok, input int req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // 0 zero, 1 one, 2 mixed, 3 none (R1)
  function automatic int rate(input logic [HALF-1:0] v, input logic [HALF-1:0] c);
    bit one = 0, zero = 0;
    for (int i = 0; i < HALF; i++) if (c[i]) begin if (v[i]) one = 1; else zero = 1; end
    if (one && zero) return 2;
    if (one) return 1;
    if (zero) return 0;
    return 3;
  endfunction

  task automatic pushBit(input logic b, input logic d, input int req);
    expItem_t it;
    it.b = b; it.d = d; it.last = 1'b0; it.req = 8'(req);
    expQ.push_back(it);
  endtask

  // Scoreboard driver: builds the expected frame, then offers the block.
  task automatic sendBlock(input logic [K-1:0] v, input logic [K-1:0] c);
    int l, r, tag, lo, hi;
    logic [4:0] code;
    int clen;
    expItem_t lastIt;
    l = rate(v[K-1:HALF], c[K-1:HALF]);
    r = rate(v[HALF-1:0], c[HALF-1:0]);
    tag = (c == '1) ? 4 : 1;
    if (l == 3 && r == 3) begin l = 0; r = 0; tag = 2; end                 // R2
    else if (l == 3) begin tag = (r == 2) ? 3 : 2; l = (r == 2) ? 0 : r; end // R2, R3
    else if (r == 3) begin tag = (l == 2) ? 3 : 2; r = (l == 2) ? 0 : l; end
    // R4 codeword table
    case ({l[1:0], r[1:0]})
      4'b0000: begin code = 5'b00000; clen = 1; end
      4'b0101: begin code = 5'b10000; clen = 2; end
      4'b0001: begin code = 5'b11000; clen = 5; end
      4'b0100: begin code = 5'b11001; clen = 5; end
      4'b0110: begin code = 5'b11010; clen = 5; end
      4'b1001: begin code = 5'b11011; clen = 5; end
      4'b0010: begin code = 5'b11100; clen = 5; end
      4'b1000: begin code = 5'b11101; clen = 5; end
      default: begin code = 5'b11110; clen = 4; end
    endcase
    for (int i = 0; i < clen; i++) pushBit(code[4-i], 1'b0, tag);
    // R5 payload, R7 don't-care handling
    lo = -1; hi = -1;
    if (l == 2 && r == 2) begin hi = K - 1; lo = 0; end
    else if (l == 2) begin hi = K - 1; lo = HALF; end
    else if (r == 2) begin hi = HALF - 1; lo = 0; end
    if (hi >= 0)
      for (int i = hi; i >= lo; i--) pushBit(v[i] & c[i], ~c[i], c[i] ? 5 : 7);
    lastIt = expQ[expQ.size()-1];
    lastIt.last = 1'b1;
    expQ[expQ.size()-1] = lastIt;
    @(posedge clk); #1;
    in_value = v; in_care = c; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_value = $urandom; in_care = $urandom;
  endtask

  // Consumer readiness: random stalls while stallMode is set.
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stallMode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // Scoreboard monitor, sampled at the falling edge.
  bit   expectIdle = 0;
  bit   stalled = 0;
  logic heldB, heldD;
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stalled && out_valid) begin   // R8 hold under stall
          check(out_bit == heldB && out_dc == heldD, 8, "stalled bit changed", int'({out_bit, out_dc}), int'({heldB, heldD}));
        end else if (stalled) begin
          check(0, 8, "out_valid dropped while stalled", 0, 1);
        end
        if (out_valid && in_ready) check(0, 9, "in_ready with out_valid", 1, 0);
        if (expectIdle) begin              // R6 frame end, R9 ready returns
          check(!out_valid && in_ready, 6, "idle after last bit", int'({out_valid, in_ready}), 1);
          expectIdle = 0;
        end
        if (out_valid && out_ready) begin
          if (expQ.size() == 0) begin
            check(0, 6, "extra frame bit", 1, 0);
          end else begin
            it = expQ.pop_front();
            check(out_bit == it.b, int'(it.req), "frame bit", int'(out_bit), int'(it.b));
            check(out_dc == it.d, 7, "dc flag", int'(out_dc), int'(it.d));
            if (it.last) expectIdle = 1;
          end
        end
        stalled = out_valid && !out_ready;
        heldB = out_bit; heldD = out_dc;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check(in_ready == 1'b1, 10, "in_ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, 10, "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, 10, "state after reset", int'({in_ready, out_valid}), 2);

    // R4: all nine codes with full care
    sendBlock(8'h00, 8'hFF);
    sendBlock(8'hFF, 8'hFF);
    sendBlock(8'h0F, 8'hFF);
    sendBlock(8'hF0, 8'hFF);
    sendBlock(8'hF5, 8'hFF);
    sendBlock(8'h5F, 8'hFF);
    sendBlock(8'h05, 8'hFF);
    sendBlock(8'h50, 8'hFF);
    sendBlock(8'h5A, 8'hFF);
    // R2: unspecified halves
    sendBlock(8'hA7, 8'h00);
    sendBlock(8'hF3, 8'hF0);
    sendBlock(8'h0C, 8'h0F);
    sendBlock(8'hEF, 8'h0F);
    // R3: unspecified half beside a mixed half
    sendBlock(8'hC5, 8'h0F);
    sendBlock(8'h5B, 8'hF0);
    // R1: sparse masks, R7: don't-cares inside payload
    sendBlock(8'h80, 8'h80);
    sendBlock(8'h7E, 8'h81);
    sendBlock(8'hA5, 8'hE7);
    sendBlock(8'h4F, 8'hCF);

    // R8: random blocks under consumer stalls
    stallMode = 1;
    for (int n = 0; n < 300; n++) begin
      logic [K-1:0] v, c;
      v = K'($urandom);
      case ($urandom % 5)
        0: c = '1;
        1: c = {K'($urandom)} & {{HALF{1'b1}}, {HALF{1'b0}}};
        2: c = {K'($urandom)} & {{HALF{1'b0}}, {HALF{1'b1}}};
        3: c = K'($urandom) | K'($urandom);
        default: c = K'($urandom) & K'($urandom);
      endcase
      sendBlock(v, c);
    end
    stallMode = 0;

    while (expQ.size() != 0 || out_valid) @(posedge clk);
    repeat (3) @(posedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule